// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block forms the byte a flash device returns on a read while an embedded program or erase algorithm is running. It takes a few flags from the algorithm controller: the operation type, the byte last handed to the program algorithm, the busy and erase-suspended flags, the over-limit flag, the flag that says the internal erase has begun, and whether the current read address lies in a sector chosen for erase. From these it builds a status byte. Bit 7 is a data-polling bit. Bits 6 and 2 are two toggle bits. Bit 5 reports that an operation ran over its limit, and bit 3 reports that the erase has begun.

The two toggle bits do not change with the clock. Each one flips on a rising edge of the read strobe. A host that reads twice in a row therefore sees bit 6 differ for as long as an algorithm runs. Bit 2 tells the host which sectors are in an erase.

A pulse on the protected-program input starts a fixed guard interval, about 2 us at 100 MHz. During this interval the block reports a program in progress. When no operation is active, the read path returns the array data unchanged. The output byte is registered: it reflects the inputs present at one clock edge and appears after that edge.

Top module: `flash_status_gen`

## Requirements
- R1: While `busy` is high and `op_erase` is low (program, including a program issued during erase suspend), `dout[7]` is the complement of `prog_data[7]`.
- R2: While `busy` and `op_erase` are high, `dout[7]` is 0.
- R3: While busy, `dout[6]` flips on every rising edge of `rd_stb`, so two consecutive reads differ. It holds its value between reads.
- R4: `dout[2]` flips on a read rising edge only when `sel_hit` is high during an erase (busy erase, or erase suspended with no program running). In all other cases it holds. During a busy program, `dout[2]` reads 0.
- R5: `dout[5]` equals `timeout` while busy. A timed-out operation keeps `dout[6]` toggling.
- R6: During a busy erase, `dout[3]` equals `erase_started`: 0 while the sector accumulation window is open and 1 once the erase has begun.
- R7: With `busy` low and `esusp` high, a read with `sel_hit` high returns status: `dout[6]` frozen, `dout[2]` toggling, and all other bits 0. A read with `sel_hit` low returns `array_data`.
- R8: A one-cycle pulse on `prot_hit` makes the block report program status (R1, R3) for GUARD_CYCLES clocks. After that, reads return `array_data`.
- R9: While status is reported, bits 4, 1 and 0 read 0.
- R10: With no operation, no suspend and no guard interval active, `dout` equals `array_data` one clock later. Once a program finishes, reads therefore return the true byte.
- R11: After a synchronous reset, `dout` is 0x00 and both toggle bits start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Embedded algorithm running |
| op_erase | input | 1 | 1 = erase, 0 = program |
| esusp | input | 1 | Erase is suspended |
| timeout | input | 1 | Operation exceeded its pulse limit |
| erase_started | input | 1 | Accumulation window closed, erase running |
| sel_hit | input | 1 | Read address is in a sector selected for erase |
| prot_hit | input | 1 | Pulse: program aimed at a protected sector |
| prog_data | input | 8 | Byte last given to the program algorithm |
| array_data | input | 8 | Array read data |
| rd_stb | input | 1 | Read strobe; a rising edge is one read |
| dout | output | 8 | Registered read byte |

## Verification
The bench compares consecutive reads rather than absolute toggle values. A design that toggled with the clock, or flipped twice per read, would show equal bytes on back-to-back busy reads and fail R3. The bench checks bit 2 both inside and outside the selected sectors, and in both the active and suspended erase states. A design that toggled bit 2 on every read, or froze it during suspend, breaks R4 or R7. It checks that bit 6 is frozen in suspend while bit 2 still moves. It checks that the guard interval ends and reads return `array_data`. It checks that a timeout raises bit 5 while bit 6 continues to toggle. A design that stopped toggling on timeout would report a false completion.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_PROG  = 2'd1,
    SRC_ERASE = 2'd2,
    SRC_SUSP  = 2'd3
  } src_t;

  localparam int POLL_BIT  = 7;
  localparam int TOG1_BIT  = 6;
  localparam int LIMIT_BIT = 5;
  localparam int TIMER_BIT = 3;
  localparam int TOG2_BIT  = 2;
endpackage

// File: rtl/fsb_guard_timer.sv
module fsb_guard_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start) cnt <= CW'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/fsb_toggle_cell.sv
module fsb_toggle_cell (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic en,
  output logic q_nxt
);
  logic q;
  assign q_nxt = q ^ (rise & en);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else q <= q_nxt;
  end
endmodule

// File: rtl/fsb_status_mux.sv
module fsb_status_mux
  import fsb_pkg::*;
#(
  parameter int DW = 8
) (
  input  src_t          src,
  input  logic [DW-1:0] prog_data,
  input  logic [DW-1:0] array_data,
  input  logic          timeout,
  input  logic          erase_started,
  input  logic          tog1,
  input  logic          tog2,
  output logic [DW-1:0] byte_out
);
  always_comb begin
    byte_out = '0;
    unique case (src)
      SRC_PROG: begin
        byte_out[POLL_BIT]  = ~prog_data[POLL_BIT];
        byte_out[TOG1_BIT]  = tog1;
        byte_out[LIMIT_BIT] = timeout;
      end
      SRC_ERASE: begin
        byte_out[POLL_BIT]  = 1'b0;
        byte_out[TOG1_BIT]  = tog1;
        byte_out[LIMIT_BIT] = timeout;
        byte_out[TIMER_BIT] = erase_started;
        byte_out[TOG2_BIT]  = tog2;
      end
      SRC_SUSP: begin
        byte_out[TOG1_BIT]  = tog1;
        byte_out[TOG2_BIT]  = tog2;
      end
      default: byte_out = array_data;
    endcase
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsb_pkg::*;
#(
  parameter int DW           = 8,
  parameter int GUARD_CYCLES = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          op_erase,
  input  logic          esusp,
  input  logic          timeout,
  input  logic          erase_started,
  input  logic          sel_hit,
  input  logic          prot_hit,
  input  logic [DW-1:0] prog_data,
  input  logic [DW-1:0] array_data,
  input  logic          rd_stb,
  output logic [DW-1:0] dout
);
  localparam int NTOG = 2;

  logic rd_q, rd_rise, guard_on;
  src_t src;
  logic [NTOG-1:0] tog_en, tog_nxt;
  logic [DW-1:0] byte_nxt;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else rd_q <= rd_stb;
  end
  assign rd_rise = rd_stb & ~rd_q;

  fsb_guard_timer #(.CYCLES(GUARD_CYCLES)) u_guard (
    .clk(clk), .rst(rst), .start(prot_hit), .active(guard_on)
  );

  // Source priority: running algorithm, protected-program guard, suspend, array.
  always_comb begin
    if (busy) src = op_erase ? SRC_ERASE : SRC_PROG;
    else if (guard_on) src = SRC_PROG;
    else if (esusp && sel_hit) src = SRC_SUSP;
    else src = SRC_ARRAY;
  end

  // Index 0: toggle on every read while running; index 1: erase-sector toggle.
  assign tog_en[0] = busy | guard_on;
  assign tog_en[1] = sel_hit & ((busy & op_erase) | (esusp & ~busy));

  genvar g;
  generate
    for (g = 0; g < NTOG; g++) begin : g_tog
      fsb_toggle_cell u_cell (
        .clk(clk), .rst(rst), .rise(rd_rise), .en(tog_en[g]), .q_nxt(tog_nxt[g])
      );
    end
  endgenerate

  fsb_status_mux #(.DW(DW)) u_mux (
    .src(src), .prog_data(prog_data), .array_data(array_data),
    .timeout(timeout), .erase_started(erase_started),
    .tog1(tog_nxt[0]), .tog2(tog_nxt[1]), .byte_out(byte_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else dout <= byte_nxt;
  end
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          op_erase,
  input logic          esusp,
  input logic          timeout,
  input logic          erase_started,
  input logic          guard_on,
  input logic [DW-1:0] prog_data,
  input logic [DW-1:0] array_data,
  input logic          rd_stb,
  input logic [DW-1:0] dout
);
  a_r1_poll_complement: assert property (@(posedge clk) disable iff (rst)
    busy && !op_erase |=> dout[7] == ~$past(prog_data[7]));

  a_r2_erase_poll_zero: assert property (@(posedge clk) disable iff (rst)
    busy && op_erase |=> dout[7] == 1'b0);

  a_r3_read_toggles: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) && rd_stb && !$past(rd_stb) |=> dout[6] != $past(dout[6]));

  a_r5_limit_bit: assert property (@(posedge clk) disable iff (rst)
    busy |=> dout[5] == $past(timeout));

  a_r6_timer_bit: assert property (@(posedge clk) disable iff (rst)
    busy && op_erase |=> dout[3] == $past(erase_started));

  a_r9_spare_zero: assert property (@(posedge clk) disable iff (rst)
    busy |=> dout[4] == 1'b0 && dout[1:0] == 2'b00);

  a_r10_passthrough: assert property (@(posedge clk) disable iff (rst)
    !busy && !esusp && !guard_on |=> dout == $past(array_data));
endmodule

bind flash_status_gen flash_status_gen_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .op_erase(op_erase), .esusp(esusp),
  .timeout(timeout), .erase_started(erase_started), .guard_on(guard_on),
  .prog_data(prog_data), .array_data(array_data), .rd_stb(rd_stb), .dout(dout)
);

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
  localparam int GUARD = 200;

  logic clk = 1'b0;
  logic rst, busy, op_erase, esusp, timeout, erase_started, sel_hit, prot_hit, rd_stb;
  logic [7:0] prog_data, array_data, dout;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_status_gen #(.DW(8), .GUARD_CYCLES(GUARD)) u_dut (
    .clk(clk), .rst(rst), .busy(busy), .op_erase(op_erase), .esusp(esusp),
    .timeout(timeout), .erase_started(erase_started), .sel_hit(sel_hit),
    .prot_hit(prot_hit), .prog_data(prog_data), .array_data(array_data),
    .rd_stb(rd_stb), .dout(dout)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    busy = 0; op_erase = 0; esusp = 0; timeout = 0; erase_started = 0;
    sel_hit = 0; prot_hit = 0; rd_stb = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    rd_stb = 1'b1;
    @(negedge clk); v = dout;
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; idle_inputs(); prog_data = 8'h00; array_data = 8'h5A;
    repeat (3) @(negedge clk);
    check("R11 reset dout", dout, 8'h00);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_passthrough();
    logic [7:0] v;
    idle_inputs(); array_data = 8'hC3;
    @(negedge clk);
    check("R10 array passthrough", dout, 8'hC3);
    rd(v);
    check("R10 read returns array", v, 8'hC3);
  endtask

  task automatic t_program();
    logic [7:0] a, b;
    idle_inputs(); prog_data = 8'h80; array_data = 8'h11; busy = 1;
    @(negedge clk);
    rd(a); rd(b);
    check("R1 poll bit complement (pd7=1)", {7'd0, a[7]}, 8'd0);
    check("R3 program reads differ bit6", {7'd0, a[6] ^ b[6]}, 8'd1);
    check("R9 spare bits / R4 bit2 zero in program", a & 8'h17, 8'h00);
    prog_data = 8'h7F;
    @(negedge clk);
    check("R1 poll bit complement (pd7=0)", {7'd0, dout[7]}, 8'd1);
    check("R3 holds between reads", {7'd0, dout[6]}, {7'd0, b[6]});
    busy = 0; array_data = 8'h7F;
    @(negedge clk);
    rd(a);
    check("R10 true data after program", a, 8'h7F);
  endtask

  task automatic t_erase();
    logic [7:0] a, b;
    idle_inputs(); busy = 1; op_erase = 1; sel_hit = 1; erase_started = 0;
    @(negedge clk);
    rd(a); rd(b);
    check("R2 erase poll zero", {7'd0, a[7]}, 8'd0);
    check("R6 window open bit3", {7'd0, a[3]}, 8'd0);
    check("R3 erase bit6 differs", {7'd0, a[6] ^ b[6]}, 8'd1);
    check("R4 bit2 toggles in selected", {7'd0, a[2] ^ b[2]}, 8'd1);
    sel_hit = 0; erase_started = 1;
    @(negedge clk);
    rd(a); rd(b);
    check("R4 bit2 holds outside selected", {7'd0, a[2] ^ b[2]}, 8'd0);
    check("R6 erase begun bit3", {7'd0, b[3]}, 8'd1);
    check("R9 spare bits zero in erase", b & 8'h13, 8'h00);
  endtask

  task automatic t_suspend();
    logic [7:0] a, b;
    idle_inputs(); esusp = 1; sel_hit = 1; array_data = 8'h99;
    @(negedge clk);
    rd(a); rd(b);
    check("R7 bit6 frozen in suspend", {7'd0, a[6] ^ b[6]}, 8'd0);
    check("R7 bit2 toggles in suspend", {7'd0, a[2] ^ b[2]}, 8'd1);
    check("R7 other bits zero in suspend", b & 8'hBB, 8'h00);
    sel_hit = 0;
    @(negedge clk);
    rd(a);
    check("R7 array outside selected", a, 8'h99);
    busy = 1; prog_data = 8'h00;
    @(negedge clk);
    rd(a); rd(b);
    check("R1 suspend-program poll", {7'd0, a[7]}, 8'd1);
    check("R3 suspend-program toggles", {7'd0, a[6] ^ b[6]}, 8'd1);
  endtask

  task automatic t_timeout();
    logic [7:0] a, b;
    idle_inputs(); busy = 1; timeout = 1; prog_data = 8'h00;
    @(negedge clk);
    rd(a); rd(b);
    check("R5 limit bit set", {7'd0, a[5]}, 8'd1);
    check("R5 still toggling", {7'd0, a[6] ^ b[6]}, 8'd1);
    timeout = 0;
    @(negedge clk);
    check("R5 limit bit follows", {7'd0, dout[5]}, 8'd0);
  endtask

  task automatic t_guard();
    logic [7:0] a, b;
    idle_inputs(); prog_data = 8'hFF; array_data = 8'h3C;
    prot_hit = 1;
    @(negedge clk);
    prot_hit = 0;
    rd(a); rd(b);
    check("R8 guard poll complement", {7'd0, a[7]}, 8'd0);
    check("R8 guard toggles", {7'd0, a[6] ^ b[6]}, 8'd1);
    repeat (GUARD + 5) @(negedge clk);
    rd(a);
    check("R8 array after guard", a, 8'h3C);
  endtask

  initial begin
    rst = 1; idle_inputs(); prog_data = 0; array_data = 0;
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_program();
    t_erase();
    t_suspend();
    t_timeout();
    t_guard();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule